// File: doc/BRIEF.md
# Byte-Lane Static Memory With Dual Chip Selects

This block is a word-organised static memory with a 16-bit data path split into a lower and an upper byte lane. It is selected by two chip selects of opposite polarity. Its controls are an active-low write strobe, an active-low output enable and one active-low enable for each byte lane. A decoder turns these controls into per-lane write and read strobes and a sleep request. A registered datapath holds the array and drives the outputs.

The bidirectional data bus is modelled as a separate input word, an output word and one output-enable bit per lane. A lane whose enable bit is low is treated as high-impedance and reads as zero. All inputs are sampled on the rising clock edge. A write commits on that edge. Read data, the lane enables and the standby indicator appear on the outputs one cycle after the edge that sampled them.

When the device is selected but both lane enables are inactive, it reports standby. A strap input, when held high, turns this lane-idle standby off.

Top module: `laneSram`

## Requirements
- R1: The device is selected only when `csN` is 0 and `csHi` is 1. While it is not selected, no array word changes, `dOutEn` becomes 2'b00 and `dOut` becomes 0 one cycle later.
- R2: A selected cycle with `weN`=0 and `lbN`=0 stores `dIn[7:0]` into bits 7:0 of the addressed word on that clock edge. With `lbN`=1, bits 7:0 keep their previous value.
- R3: A selected cycle with `weN`=0 and `ubN`=0 stores `dIn[15:8]` into bits 15:8 of the addressed word. With `ubN`=1, bits 15:8 keep their previous value.
- R4: A selected cycle with `weN`=1 and `oeN`=0 is a read. One cycle later, `dOutEn[0]` equals the inverse of `lbN` and `dOutEn[1]` equals the inverse of `ubN`. Each enabled lane of `dOut` carries the corresponding byte of the addressed word.
- R5: A lane whose `dOutEn` bit is 0 shows 0 on its bits of `dOut`. Both bits of `dOutEn` are 0 one cycle after a cycle with `oeN`=1, or with `lbN` and `ubN` both 1.
- R6: When `weN` and `oeN` are both 0 in a selected cycle, the cycle is a write, and `dOutEn` is 2'b00 one cycle later.
- R7: `standby` is 1 one cycle after any cycle in which the device is not selected.
- R8: One cycle after a selected cycle, `standby` is 1 exactly when `lbN`=1, `ubN`=1 and `lanePdOff`=0. Otherwise it is 0.
- R9: While `rstN` is 0, `dOutEn` is 2'b00, `dOut` is 0 and `standby` is 1.
- R10: The array has 2**ADDR_W independent words. Writing one address leaves every other address unchanged, including address 0 and the highest address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset for the output registers |
| csN | input | 1 | Active-low chip select |
| csHi | input | 1 | Active-high chip select |
| weN | input | 1 | Active-low write strobe |
| oeN | input | 1 | Active-low output enable |
| lbN | input | 1 | Active-low enable for lane 0 (bits 7:0) |
| ubN | input | 1 | Active-low enable for lane 1 (bits 15:8) |
| lanePdOff | input | 1 | Strap; 1 turns off the lane-idle standby |
| addr | input | ADDR_W | Word address |
| dIn | input | 16 | Write data |
| dOut | output | 16 | Read data; zero on lanes not driven |
| dOutEn | output | 2 | Per-lane drive enable (bit 0 lower lane, bit 1 upper lane) |
| standby | output | 1 | Standby indicator |

## Verification
The hardest situations to reach are partial-lane writes followed by a read that shows both the merged new byte and the untouched old byte. Every word must hold known data first, so the stimulus begins by filling the whole array with distinct values. It then performs directed half-word writes and read-backs, including at address 0 and at the highest address. After that it sweeps all 128 combinations of the seven control inputs several times, with random addresses and data. A behavioural array is compared against every output on every cycle.

// File: rtl/laneSramPkg.sv
package laneSramPkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;

  typedef struct packed {
    logic [LANES-1:0] wr;
    logic [LANES-1:0] rd;
    logic             sleep;
  } laneStrobe_t;
endpackage

// File: rtl/laneSramCtl.sv
module laneSramCtl
  import laneSramPkg::*;
(
  input  logic        csN,
  input  logic        csHi,
  input  logic        weN,
  input  logic        oeN,
  input  logic        lbN,
  input  logic        ubN,
  input  logic        lanePdOff,
  output laneStrobe_t strobe
);
  logic selected;
  logic wrCycle;
  logic rdCycle;
  logic [LANES-1:0] laneOn;

  assign selected = !csN && csHi;
  assign wrCycle  = selected && !weN;
  assign rdCycle  = selected && weN && !oeN;
  assign laneOn   = {!ubN, !lbN};

  always_comb begin
    strobe.wr    = wrCycle ? laneOn : '0;
    strobe.rd    = rdCycle ? laneOn : '0;
    strobe.sleep = !selected || (!lanePdOff && (laneOn == '0));
  end

  // R6
  always_comb begin
    wr_rd_excl_chk: assert ((strobe.wr == '0) || (strobe.rd == '0))
      else $error("write and read strobes active together");
  end
endmodule

// File: rtl/laneSramDp.sv
module laneSramDp
  import laneSramPkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneStrobe_t       strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dIn,
  output logic [WORD_W-1:0] dOut,
  output logic [LANES-1:0]  dOutEn,
  output logic              standby
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobe.wr[g]) laneMem[addr] <= dIn[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dOut[g*LANE_W +: LANE_W] <= '0;
        dOutEn[g]                <= 1'b0;
      end else begin
        dOut[g*LANE_W +: LANE_W] <= strobe.rd[g] ? laneMem[addr] : '0;
        dOutEn[g]                <= strobe.rd[g];
      end
    end

    // R5
    lane_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      !dOutEn[g] |-> (dOut[g*LANE_W +: LANE_W] == '0))
      else $error("undriven lane carries data");
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) standby <= 1'b1;
    else       standby <= strobe.sleep;
  end

  // R4
  read_awake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dOutEn != '0) |-> !standby)
    else $error("lane driven during standby");
endmodule

// File: rtl/laneSram.sv
module laneSram
  import laneSramPkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              csHi,
  input  logic              weN,
  input  logic              oeN,
  input  logic              lbN,
  input  logic              ubN,
  input  logic              lanePdOff,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dIn,
  output logic [15:0]       dOut,
  output logic [1:0]        dOutEn,
  output logic              standby
);
  laneStrobe_t strobe;

  laneSramCtl i_ctl (
    .csN(csN), .csHi(csHi), .weN(weN), .oeN(oeN),
    .lbN(lbN), .ubN(ubN), .lanePdOff(lanePdOff), .strobe(strobe)
  );

  laneSramDp #(.ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr), .dIn(dIn),
    .dOut(dOut), .dOutEn(dOutEn), .standby(standby)
  );

  // R6
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && csHi && !weN) |=> (dOutEn == 2'b00))
    else $error("bus driven after write cycle");

  // R7
  deselect_sleep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!csN && csHi) |=> (standby && dOutEn == 2'b00))
    else $error("deselected device awake or driving");

  // R8
  strap_awake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && csHi && lanePdOff) |=> !standby)
    else $error("lane-idle standby entered with strap set");

  // R5
  oe_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    oeN |=> (dOutEn == 2'b00))
    else $error("bus driven with output enable off");
endmodule

// File: tb/test_laneSram.sv
`timescale 1ns/1ps
module test_laneSram;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, csHi = 1'b0, weN = 1'b1, oeN = 1'b1;
  logic lbN = 1'b1, ubN = 1'b1, lanePdOff = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] dIn = '0;
  logic [15:0] dOut;
  logic [1:0]  dOutEn;
  logic        standby;

  int checks = 0;
  int fails = 0;
  logic [15:0] refMem [DEPTH];

  always #10 clk = ~clk;

  laneSram #(.ADDR_W(AW)) i_laneSram (
    .clk(clk), .rstN(rstN), .csN(csN), .csHi(csHi), .weN(weN), .oeN(oeN),
    .lbN(lbN), .ubN(ubN), .lanePdOff(lanePdOff), .addr(addr), .dIn(dIn),
    .dOut(dOut), .dOutEn(dOutEn), .standby(standby)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, compare at the next falling edge.
  task automatic step(logic c0, logic c1, logic w, logic o, logic l, logic u,
                      logic p, logic [AW-1:0] a, logic [15:0] d, string tag);
    logic sel;
    logic [1:0] expEn;
    logic [15:0] expOut;
    logic expSb;
    string tEn, tSb;
    csN = c0; csHi = c1; weN = w; oeN = o; lbN = l; ubN = u;
    lanePdOff = p; addr = a; dIn = d;
    sel = !c0 && c1;
    expEn = (sel && w && !o) ? {!u, !l} : 2'b00;
    expOut = {expEn[1] ? refMem[a][15:8] : 8'h00,
              expEn[0] ? refMem[a][7:0]  : 8'h00};
    expSb = !sel || (l && u && !p);
    if (!sel) tEn = "R1";
    else if (!w) tEn = "R6";
    else if (o || (l && u)) tEn = "R5";
    else tEn = "R4";
    tSb = sel ? "R8" : "R7";
    if (tag != "") begin tEn = tag; end
    if (sel && !w) begin
      if (!l) refMem[a][7:0] = d[7:0];
      if (!u) refMem[a][15:8] = d[15:8];
    end
    @(posedge clk);
    @(negedge clk);
    check(tEn, {14'd0, dOutEn}, {14'd0, expEn});
    check(tEn, dOut, expOut);
    check(tSb, {15'd0, standby}, {15'd0, expSb});
  endtask

  initial begin
    #(20ns * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", {14'd0, dOutEn}, 16'd0);
    check("R9", dOut, 16'd0);
    check("R9", {15'd0, standby}, 16'd1);
    rstN = 1'b1;

    // Fill the array with distinct words (R10)
    for (int a = 0; a < DEPTH; a++)
      step(0, 1, 0, 1, 0, 0, 0, AW'(a), 16'(a * 40503 + 7), "R10");
    for (int a = 0; a < DEPTH; a += 97)
      step(0, 1, 1, 0, 0, 0, 0, AW'(a), 16'h0, "R10");

    // R2: lower-lane-only write then read back
    step(0, 1, 0, 1, 0, 0, 0, AW'(5), 16'hAAAA, "R2");
    step(0, 1, 0, 1, 0, 1, 0, AW'(5), 16'h1234, "R2");
    step(0, 1, 1, 0, 0, 0, 0, AW'(5), 16'h0, "R2");
    // R3: upper-lane-only write then read back
    step(0, 1, 0, 1, 1, 0, 0, AW'(5), 16'h5678, "R3");
    step(0, 1, 1, 0, 0, 0, 0, AW'(5), 16'h0, "R3");
    // R10: extreme addresses do not alias
    step(0, 1, 0, 0, 0, 0, 0, AW'(0), 16'hBEEF, "R10");
    step(0, 1, 0, 0, 0, 0, 0, AW'(DEPTH - 1), 16'hCAFE, "R10");
    step(0, 1, 1, 0, 0, 0, 0, AW'(0), 16'h0, "R10");
    step(0, 1, 1, 0, 0, 0, 0, AW'(DEPTH - 1), 16'h0, "R10");
    // R1: deselected write attempts leave the word intact
    step(1, 1, 0, 0, 0, 0, 0, AW'(0), 16'h1111, "R1");
    step(0, 0, 0, 0, 0, 0, 0, AW'(0), 16'h2222, "R1");
    step(0, 1, 1, 0, 0, 0, 0, AW'(0), 16'h0, "R1");

    // Sweep every control combination with random address and data
    for (int r = 0; r < 6; r++) begin
      for (int c = 0; c < 128; c++) begin
        step(c[0], c[1], c[2], c[3], c[4], c[5], c[6],
             AW'($urandom % DEPTH), 16'($urandom), "");
        step(0, 1, 1, 0, 0, 0, 0, AW'($urandom % DEPTH), 16'h0, "");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule